// File: doc/BRIEF.md
# Masked Status-Change Interrupt Controller

This block watches the live status bits of several channels (four by default) and remembers every bit that has changed since the last time software read that channel's status register. A global mask, one bit for each status bit position, decides which bits are allowed to raise an interrupt. Any unmasked pending change drives three indications: a level interrupt pin, an INT flag inside each channel's status register image, and a one-clock-period request pulse meant for the management data line, issued only while that bus is idle.

Reads arrive as single-cycle strobes carrying a register address and the upper device-address bits from the frame. The serial framing itself lives elsewhere. A read of a channel status address returns that channel's status, its INT flag and its channel number, and clears that channel's pending changes. A read of a special alias address returns the lowest-numbered channel that has a pending change. The host can find the source of an interrupt with one access and clear it.

Top module: `sirq_ctrl`

## Requirements
- R1: A change of an unmasked status bit on `stat_i`, seen at a clock edge, sets that channel's pending state at that edge, so `irq_o` is high in the following cycle.
- R2: A change of a bit whose `mask_wdata` bit was written as 1 (1 = masked) sets nothing and never raises `irq_o`, even after the mask is cleared again.
- R3: A read strobe at address `STAT_BASE + c` (default base 16) returns, one cycle later with `rd_vld` high, `rd_data` = {channel number c in bits [10:9], INT flag in bit 8, sampled status in bits [7:0]}. INT is 1 when channel c had an unmasked pending change at the strobe.
- R4: A read of a channel clears that channel's pending state. `irq_o` drops in the cycle after the read once no channel remains pending.
- R5: A status change that occurs at the same edge as the clearing read of its channel stays pending. `irq_o` remains high.
- R6: A read at the alias address 30 returns the register image of the lowest-numbered pending channel and clears only that channel. With nothing pending it returns channel 0 with INT = 0.
- R7: A read strobe whose `rd_phy` differs from `phy_pins` is ignored. No `rd_vld`, and no pending state is cleared.
- R8: After each rise of `irq_o`, `mdio_pulse` rises at an edge where `mdc_rise` and `bus_idle` are both high. It then stays high exactly until the next `mdc_rise`, which is one MDC period. While `bus_idle` is low it does not start.
- R9: After reset `irq_o`, `rd_vld` and `mdio_pulse` are low. The status present when reset is released is taken as the reference and is not reported as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_i | input | NUM_CH*STAT_W | Live status bits, channel c in slice c |
| mask_we | input | 1 | Write strobe for the global mask |
| mask_wdata | input | STAT_W | Mask value, 1 = bit masked |
| phy_pins | input | PHY_W | Upper device-address bits strapped on pins |
| rd_stb | input | 1 | Register read strobe, one cycle |
| rd_phy | input | PHY_W | Upper device-address bits from the frame |
| rd_addr | input | ADDR_W | Register address of the read |
| rd_vld | output | 1 | Read data valid |
| rd_data | output | STAT_W+1+CH_W | Channel status register image |
| irq_o | output | 1 | Level interrupt pin |
| mdc_rise | input | 1 | Strobe marking each management clock rising edge |
| bus_idle | input | 1 | Management bus idle |
| mdio_pulse | output | 1 | Interrupt request pulse for the data line |

## Verification
On every cycle the checker confirms several things. An interrupt rise is always preceded by a status change. A valid read always comes from a strobe with a matching device address. A channel read reports its own channel number. An alias read taken while the interrupt was up carries INT = 1. The data-line pulse starts only on an idle MDC edge and ends only on an MDC edge. Only the bench scenarios can show the history-dependent parts: masked changes staying silent after unmasking, a change landing on the clearing read, the lowest-first order of alias reads, the reset reference, and the exact pulse width.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int ADDR_W = 5;
   localparam int PHY_W  = 3;

   typedef enum logic [1:0] {
      RK_NONE  = 2'd0,
      RK_CHAN  = 2'd1,
      RK_ALIAS = 2'd2
   } rd_kind_e;
endpackage

// File: rtl/sirq_chan_flags.sv
module sirq_chan_flags #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              primed,
   input  logic [STAT_W-1:0] stat_i,
   input  logic [STAT_W-1:0] mask,
   input  logic              clr,
   output logic [STAT_W-1:0] stat_q,
   output logic              pend
);
   logic [STAT_W-1:0] flags_q;
   logic [STAT_W-1:0] delta;

   always_comb begin
      delta = primed ? ((stat_i ^ stat_q) & ~mask) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q  <= '0;
         flags_q <= '0;
      end else begin
         stat_q  <= stat_i;
         flags_q <= (clr ? '0 : flags_q) | delta;
      end
   end

   assign pend = |(flags_q & ~mask);
endmodule

// File: rtl/sirq_prio_pick.sv
module sirq_prio_pick #(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] req,
   output logic [CH_W-1:0]   idx,
   output logic              any
);
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = CH_W'(i);
            any = 1'b1;
         end
      end
   end
endmodule

// File: rtl/sirq_pulse_gen.sv
module sirq_pulse_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic irq,
   input  logic mdc_rise,
   input  logic bus_idle,
   output logic pulse
);
   logic irq_q;
   logic req_q;
   logic req_n;
   logic pulse_n;

   always_comb begin
      req_n   = req_q;
      pulse_n = pulse;
      if (irq && !irq_q) req_n = 1'b1;
      else if (!irq)     req_n = 1'b0;
      if (mdc_rise) begin
         if (pulse) begin
            pulse_n = 1'b0;
         end else if (req_q && bus_idle) begin
            pulse_n = 1'b1;
            req_n   = 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         req_q <= 1'b0;
         pulse <= 1'b0;
      end else begin
         irq_q <= irq;
         req_q <= req_n;
         pulse <= pulse_n;
      end
   end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
   import sirq_pkg::*;
#(
   parameter int              NUM_CH     = 4,
   parameter int              STAT_W     = 8,
   parameter int              STAT_BASE  = 16,
   parameter int              ALIAS_ADDR = 30,
   parameter logic [STAT_W-1:0] MASK_RST = '0,
   localparam int             CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int             REG_W      = STAT_W + 1 + CH_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH*STAT_W-1:0] stat_i,
   input  logic                     mask_we,
   input  logic [STAT_W-1:0]        mask_wdata,
   input  logic [PHY_W-1:0]         phy_pins,
   input  logic                     rd_stb,
   input  logic [PHY_W-1:0]         rd_phy,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic                     rd_vld,
   output logic [REG_W-1:0]         rd_data,
   output logic                     irq_o,
   input  logic                     mdc_rise,
   input  logic                     bus_idle,
   output logic                     mdio_pulse
);
   if (NUM_CH < 2 || NUM_CH != (1 << CH_W)) begin : g_bad_ch
      $error("NUM_CH must be a power of two of at least 2");
   end
   if (STAT_W < 1) begin : g_bad_w
      $error("STAT_W must be positive");
   end
   if (STAT_BASE + NUM_CH > (1 << ADDR_W) ||
       (ALIAS_ADDR >= STAT_BASE && ALIAS_ADDR < STAT_BASE + NUM_CH)) begin : g_bad_map
      $error("status window overlaps alias or exceeds address space");
   end

   logic [STAT_W-1:0] mask_q;
   logic              primed_q;
   logic [NUM_CH-1:0] pend;
   logic [NUM_CH-1:0] clr;
   logic [STAT_W-1:0] stat_q_a [NUM_CH];
   logic [CH_W-1:0]   pick_idx;
   logic              pick_any;
   rd_kind_e          kind;
   logic [CH_W-1:0]   sel_ch;
   logic              hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q   <= MASK_RST;
         primed_q <= 1'b0;
      end else begin
         primed_q <= 1'b1;
         if (mask_we) mask_q <= mask_wdata;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      sirq_chan_flags #(.STAT_W(STAT_W)) u_flags (
         .clk    (clk),
         .rst_n  (rst_n),
         .primed (primed_q),
         .stat_i (stat_i[c*STAT_W +: STAT_W]),
         .mask   (mask_q),
         .clr    (clr[c]),
         .stat_q (stat_q_a[c]),
         .pend   (pend[c])
      );
   end

   sirq_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
      .req (pend),
      .idx (pick_idx),
      .any (pick_any)
   );

   always_comb begin
      hit  = rd_stb && (rd_phy == phy_pins);
      kind = RK_NONE;
      sel_ch = '0;
      if (hit) begin
         if (int'(rd_addr) == ALIAS_ADDR) begin
            kind   = RK_ALIAS;
            sel_ch = pick_idx;
         end else if (int'(rd_addr) >= STAT_BASE && int'(rd_addr) < STAT_BASE + NUM_CH) begin
            kind   = RK_CHAN;
            sel_ch = CH_W'(int'(rd_addr) - STAT_BASE);
         end
      end
      clr = '0;
      if (kind == RK_CHAN || (kind == RK_ALIAS && pick_any)) clr[sel_ch] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_vld  <= 1'b0;
         rd_data <= '0;
      end else begin
         rd_vld <= (kind != RK_NONE);
         if (kind != RK_NONE) rd_data <= {sel_ch, pend[sel_ch], stat_q_a[sel_ch]};
      end
   end

   assign irq_o = |pend;

   sirq_pulse_gen u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq      (irq_o),
      .mdc_rise (mdc_rise),
      .bus_idle (bus_idle),
      .pulse    (mdio_pulse)
   );
endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk #(
   parameter int NUM_CH     = 4,
   parameter int STAT_W     = 8,
   parameter int STAT_BASE  = 16,
   parameter int ALIAS_ADDR = 30,
   localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int REG_W     = STAT_W + 1 + CH_W
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [NUM_CH*STAT_W-1:0] stat_i,
   input logic [2:0]               phy_pins,
   input logic                     rd_stb,
   input logic [2:0]               rd_phy,
   input logic [4:0]               rd_addr,
   input logic                     rd_vld,
   input logic [REG_W-1:0]         rd_data,
   input logic                     irq_o,
   input logic                     mdc_rise,
   input logic                     bus_idle,
   input logic                     mdio_pulse
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $rose(irq_o) |-> ($past(stat_i) != $past(stat_i, 2))); // R1

   AST_RD_PHY: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      rd_vld |-> $past(rd_stb && (rd_phy == phy_pins))); // R7

   AST_CHAN_NUM: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (rd_vld && $past(int'(rd_addr) >= STAT_BASE && int'(rd_addr) < STAT_BASE + NUM_CH))
      |-> (int'(rd_data[REG_W-1 -: CH_W]) == $past(int'(rd_addr)) - STAT_BASE)); // R3

   AST_ALIAS_INT: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      (rd_vld && $past(int'(rd_addr) == ALIAS_ADDR) && $past(irq_o)) |-> rd_data[STAT_W]); // R6

   AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $rose(mdio_pulse) |-> $past(bus_idle && mdc_rise)); // R8

   AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
      $fell(mdio_pulse) |-> $past(mdc_rise)); // R8
endmodule

bind sirq_ctrl sirq_ctrl_chk #(
   .NUM_CH(NUM_CH), .STAT_W(STAT_W), .STAT_BASE(STAT_BASE), .ALIAS_ADDR(ALIAS_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .phy_pins(phy_pins), .rd_stb(rd_stb),
   .rd_phy(rd_phy), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data),
   .irq_o(irq_o), .mdc_rise(mdc_rise), .bus_idle(bus_idle), .mdio_pulse(mdio_pulse)
);

// File: tb/tb_sirq_ctrl.sv
`timescale 1ns/1ps
module tb_sirq_ctrl;
   localparam int NC = 4;
   localparam int SW = 8;
   localparam int RW = 11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NC*SW-1:0] stat = '0;
   logic mask_we = 1'b0;
   logic [SW-1:0] mask_wdata = '0;
   logic [2:0] phy_pins = 3'b101;
   logic rd_stb = 1'b0;
   logic [2:0] rd_phy = 3'b101;
   logic [4:0] rd_addr = '0;
   logic rd_vld;
   logic [RW-1:0] rd_data;
   logic irq_o;
   logic mdc_rise = 1'b0;
   logic bus_idle = 1'b1;
   logic mdio_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [RW-1:0] expq[$];
   string tagq[$];

   always #2.5 clk = ~clk;

   sirq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .stat_i(stat), .mask_we(mask_we), .mask_wdata(mask_wdata),
      .phy_pins(phy_pins), .rd_stb(rd_stb), .rd_phy(rd_phy), .rd_addr(rd_addr),
      .rd_vld(rd_vld), .rd_data(rd_data), .irq_o(irq_o), .mdc_rise(mdc_rise),
      .bus_idle(bus_idle), .mdio_pulse(mdio_pulse)
   );

   // MDC strobe: one clock in four
   int mdc_cnt = 0;
   always @(negedge clk) begin
      mdc_cnt  <= (mdc_cnt + 1) % 4;
      mdc_rise <= (mdc_cnt == 3);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rd_vld) begin
         checks++;
         if (expq.size() == 0) begin
            errors++;
            $display("FAIL R7 actual=%0h expected=no read data", rd_data);
         end else begin
            logic [RW-1:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s actual=%0h expected=%0h", t, rd_data, e);
            end
         end
      end
   end

   function automatic logic [RW-1:0] img(input int ch, input bit intf, input logic [SW-1:0] s);
      return {ch[1:0], intf, s};
   endfunction

   task automatic tick(); @(negedge clk); endtask

   task automatic do_read(input int addr, input bit match, input bit valid,
                          input logic [RW-1:0] exp, input string tag);
      rd_stb  = 1'b1;
      rd_addr = addr[4:0];
      rd_phy  = match ? phy_pins : ~phy_pins;
      if (valid) begin
         expq.push_back(exp);
         tagq.push_back(tag);
      end
      tick();
      rd_stb = 1'b0;
   endtask

   function automatic logic [SW-1:0] sl(input int ch);
      return stat[ch*SW +: SW];
   endfunction

   initial begin
      int w;
      stat[2*SW +: SW] = 8'h5A;
      repeat (3) tick();
      rst_n = 1'b1;
      tick(); tick();
      check("R9 irq", irq_o, 0);
      check("R9 rd_vld", rd_vld, 0);
      check("R9 pulse", mdio_pulse, 0);

      // R1 change sets irq
      stat[1*SW] = 1'b1;
      tick();
      check("R1 irq", irq_o, 1);
      // R3/R4 read channel 1
      do_read(17, 1, 1, img(1, 1, 8'h01), "R3 ch1");
      check("R4 irq clear", irq_o, 0);
      do_read(18, 1, 1, img(2, 0, 8'h5A), "R9 reference");

      // R2 masked bit
      mask_we = 1'b1; mask_wdata = 8'h80; tick(); mask_we = 1'b0;
      stat[0*SW + 7] = 1'b1;
      tick(); tick();
      check("R2 masked", irq_o, 0);
      mask_we = 1'b1; mask_wdata = 8'h00; tick(); mask_we = 1'b0;
      tick();
      check("R2 after unmask", irq_o, 0);
      do_read(16, 1, 1, img(0, 0, 8'h80), "R2 ch0 int");

      // R6 alias lowest first
      stat[3*SW + 2] = 1'b1;
      stat[1*SW + 4] = 1'b1;
      tick();
      do_read(30, 1, 1, img(1, 1, 8'h11), "R6 alias ch1");
      check("R6 ch3 still pending", irq_o, 1);
      do_read(30, 1, 1, img(3, 1, 8'h04), "R6 alias ch3");
      check("R6 irq clear", irq_o, 0);
      do_read(30, 1, 1, img(0, 0, 8'h80), "R6 alias none");

      // R5 change at clearing read
      stat[2*SW + 0] = 1'b1;
      tick();
      stat[2*SW + 7] = 1'b1;
      do_read(18, 1, 1, img(2, 1, 8'h5B), "R5 read");
      check("R5 still pending", irq_o, 1);
      do_read(18, 1, 1, img(2, 1, 8'hDB), "R5 reread");
      check("R5 irq clear", irq_o, 0);

      // R7 wrong device address
      stat[0*SW + 1] = 1'b1;
      tick();
      do_read(16, 0, 0, '0, "R7");
      check("R7 no rd_vld", rd_vld, 0);
      check("R7 still pending", irq_o, 1);
      do_read(16, 1, 1, img(0, 1, 8'h82), "R7 later read");
      check("R7 cleared by valid read", irq_o, 0);

      // R8 pulse held off while busy, then one MDC period
      repeat (8) tick();
      bus_idle = 1'b0;
      stat[3*SW + 5] = 1'b1;
      w = 0;
      repeat (12) begin tick(); if (mdio_pulse) w++; end
      check("R8 no pulse while busy", w, 0);
      bus_idle = 1'b1;
      w = 0;
      while (!mdio_pulse && w < 20) begin tick(); w++; end
      check("R8 pulse started", mdio_pulse, 1);
      w = 0;
      while (mdio_pulse && w < 20) begin tick(); w++; end
      check("R8 pulse width", w, 4);
      do_read(19, 1, 1, img(3, 1, 8'h24), "R8 ch3");
      repeat (3) tick();
      check("R8 queue drained", expq.size(), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule